// File: doc/BRIEF.md
# Serial Status Flag Register with Arbitration and Overrun Detection

This block holds the four sticky status flags of a serial port that runs either a two-wire multi-master bus (I2C) or a clocked-synchronous format. The serial engine feeds it single-cycle event strobes: a received byte moved into the data register, an acknowledge slot sampled, a stop condition, an SCL rising edge, a start condition, and the last bit of a synchronous frame. It also feeds the level this device drives on SDA, the level seen on the SDA pin, and the mode bits. From these inputs the block decides when each flag sets. This includes loss of arbitration while acting as master and, in synchronous format, overrun of an unread byte. The arbitration-loss and overrun conditions share one flag bit.

The CPU sees the flags as one status byte. A flag can only be cleared by a two-step handshake: the CPU first reads the byte while the flag is 1, and then writes 0 to that bit. Each flag keeps a private arm bit. A status read loads the arm bit from the flag, and any status write drops it. The receive-full flag can also be cleared by reading the receive data register. An interrupt request is raised when any flag is set whose enable bit is also set.

Top module: `ser_status_flags`

## Requirements
- R1: After reset the status byte reads 0, and bits that hold no flag read 0 at all times.
- R2: Receive-full (status bit 5) sets on `ev_rx_xfer` and clears when `rd_rxdata` is pulsed.
- R3: A status write with 0 in a flag bit clears that flag only if a status read returned that flag as 1 since the last status write. A write of 1 changes nothing, and any status write disarms all flags.
- R4: No-acknowledge (bit 4) sets when `ev_ack_sampled` arrives with `ack_nack`=1 in transmit mode, and only while `ack_chk_en` is 1.
- R5: Stop-seen (bit 3) sets on `ev_stop` only if a byte transfer (`ev_rx_xfer`, `ev_ack_sampled` or `ev_last_bit`) happened since the previous stop or reset.
- R6: In master transmit mode with the I2C format (`mode_sync`=0), arbitration-lost (bit 2) sets on `ev_scl_rise` when `sda_drive` differs from `sda_pin`. It does not set when the device is not master or the levels match.
- R7: In master mode with the I2C format, bit 2 sets on `ev_start` while `sda_drive` is 1. It does not set when `sda_drive` is 0.
- R8: With `mode_sync`=1, bit 2 acts as overrun and sets on `ev_last_bit` while receive-full is already 1. It does not set when receive-full is 0.
- R9: When a set event and a valid clear (by write or by data read) hit the same flag in one cycle, the flag stays 1.
- R10: `irq` is 1 exactly when some status bit is 1 together with the matching bit of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_xfer | input | 1 | Received byte moved into the data register |
| ev_ack_sampled | input | 1 | Acknowledge slot sampled |
| ack_nack | input | 1 | Sampled acknowledge level, 1 = no acknowledge |
| ev_stop | input | 1 | Stop condition detected |
| ev_scl_rise | input | 1 | SCL rising edge |
| ev_start | input | 1 | Start condition detected |
| ev_last_bit | input | 1 | Final bit of a synchronous frame received |
| sda_drive | input | 1 | Level this device drives on SDA |
| sda_pin | input | 1 | Level observed on SDA |
| mode_master | input | 1 | Master mode |
| mode_tx | input | 1 | Transmit mode |
| mode_sync | input | 1 | 1 = clocked-synchronous format, 0 = I2C |
| ack_chk_en | input | 1 | Enable acknowledge checking |
| rd_status | input | 1 | CPU read of the status byte |
| wr_status | input | 1 | CPU write of the status byte |
| wr_data | input | DW | Data written with `wr_status` |
| rd_rxdata | input | 1 | CPU read of the receive data register |
| irq_en | input | DW | Per-bit interrupt enables aligned to the status byte |
| status_out | output | DW | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit status byte with the flags at bits 5, 4, 3 and 2, and bits 7, 6, 1 and 0 unused. Because the unused bits stay in the byte, an all-ones write can show that writing 1 changes nothing. A full-width compare also catches any stray bit. Since the interrupt enables line up with the byte, one enable pattern can select a single flag. The case where set and clear meet in one cycle is driven through both clear paths, the status write and the data read.

// File: rtl/ser_status_flags.sv
module ser_status_flags #(
  parameter int DW      = 8,
  parameter int BIT_RDF = 5,
  parameter int BIT_NAK = 4,
  parameter int BIT_STP = 3,
  parameter int BIT_ALO = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rx_xfer,
  input  logic          ev_ack_sampled,
  input  logic          ack_nack,
  input  logic          ev_stop,
  input  logic          ev_scl_rise,
  input  logic          ev_start,
  input  logic          ev_last_bit,
  input  logic          sda_drive,
  input  logic          sda_pin,
  input  logic          mode_master,
  input  logic          mode_tx,
  input  logic          mode_sync,
  input  logic          ack_chk_en,
  input  logic          rd_status,
  input  logic          wr_status,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_rxdata,
  input  logic [DW-1:0] irq_en,
  output logic [DW-1:0] status_out,
  output logic          irq
);
  localparam int NF = 4;

  logic [NF-1:0] flg, arm, set_ev, clr_ev, wzero;
  logic          frame_seen;

  wire i2c_master = mode_master & ~mode_sync;
  wire al_tx      = i2c_master & mode_tx & ev_scl_rise & (sda_drive ^ sda_pin);
  wire al_start   = i2c_master & ev_start & sda_drive;
  wire ovr        = mode_sync & ev_last_bit & flg[0];

  assign set_ev = {al_tx | al_start | ovr,
                   ev_stop & frame_seen,
                   ev_ack_sampled & ack_nack & ack_chk_en & mode_tx,
                   ev_rx_xfer};

  assign wzero  = ~{wr_data[BIT_ALO], wr_data[BIT_STP], wr_data[BIT_NAK], wr_data[BIT_RDF]};
  assign clr_ev = ({NF{wr_status}} & arm & wzero) | {{(NF-1){1'b0}}, rd_rxdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg        <= '0;
      arm        <= '0;
      frame_seen <= 1'b0;
    end else begin
      flg        <= set_ev | (flg & ~clr_ev);
      arm        <= wr_status ? '0 : (rd_status ? flg : arm);
      frame_seen <= (frame_seen & ~ev_stop) | ev_rx_xfer | ev_ack_sampled | ev_last_bit;
    end
  end

  always_comb begin
    status_out          = '0;
    status_out[BIT_RDF] = flg[0];
    status_out[BIT_NAK] = flg[1];
    status_out[BIT_STP] = flg[2];
    status_out[BIT_ALO] = flg[3];
  end

  assign irq = |(status_out & irq_en);
endmodule

// File: rtl/ser_status_flags_chk.sv
module ser_status_flags_chk #(
  parameter int DW      = 8,
  parameter int BIT_RDF = 5,
  parameter int BIT_NAK = 4,
  parameter int BIT_STP = 3,
  parameter int BIT_ALO = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_rx_xfer,
  input logic          ev_ack_sampled,
  input logic          ack_nack,
  input logic          ev_scl_rise,
  input logic          ev_last_bit,
  input logic          sda_drive,
  input logic          sda_pin,
  input logic          mode_master,
  input logic          mode_tx,
  input logic          mode_sync,
  input logic          ack_chk_en,
  input logic          wr_status,
  input logic          rd_rxdata,
  input logic [DW-1:0] status_out
);
  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> status_out == '0);

  a_r2_rdrf_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_xfer |=> status_out[BIT_RDF]);

  a_r3_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[BIT_STP] && !wr_status |=> status_out[BIT_STP]);

  a_r4_nack_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_sampled && ack_nack && ack_chk_en && mode_tx |=> status_out[BIT_NAK]);

  a_r6_arb_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    mode_master && mode_tx && !mode_sync && ev_scl_rise && (sda_drive != sda_pin)
    |=> status_out[BIT_ALO]);

  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sync && ev_last_bit && status_out[BIT_RDF] |=> status_out[BIT_ALO]);

  a_r9_rdrf_read_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[BIT_RDF] && !wr_status && !rd_rxdata |=> status_out[BIT_RDF]);
endmodule

bind ser_status_flags ser_status_flags_chk #(
  .DW(DW), .BIT_RDF(BIT_RDF), .BIT_NAK(BIT_NAK), .BIT_STP(BIT_STP), .BIT_ALO(BIT_ALO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rx_xfer(ev_rx_xfer), .ev_ack_sampled(ev_ack_sampled),
  .ack_nack(ack_nack), .ev_scl_rise(ev_scl_rise), .ev_last_bit(ev_last_bit),
  .sda_drive(sda_drive), .sda_pin(sda_pin), .mode_master(mode_master),
  .mode_tx(mode_tx), .mode_sync(mode_sync), .ack_chk_en(ack_chk_en),
  .wr_status(wr_status), .rd_rxdata(rd_rxdata), .status_out(status_out)
);

// File: tb/ser_status_flags_test.sv
module ser_status_flags_test;
  localparam logic [7:0] RDF = 8'h20, NAK = 8'h10, STP = 8'h08, ALO = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_rx_xfer, ev_ack_sampled, ack_nack, ev_stop, ev_scl_rise, ev_start, ev_last_bit;
  logic sda_drive, sda_pin, mode_master, mode_tx, mode_sync, ack_chk_en;
  logic rd_status, wr_status, rd_rxdata;
  logic [7:0] wr_data, irq_en, status_out;
  logic irq;

  typedef struct { logic [7:0] st; logic ir; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_status_flags uut (
    .clk(clk), .rst_n(rst_n), .ev_rx_xfer(ev_rx_xfer), .ev_ack_sampled(ev_ack_sampled),
    .ack_nack(ack_nack), .ev_stop(ev_stop), .ev_scl_rise(ev_scl_rise), .ev_start(ev_start),
    .ev_last_bit(ev_last_bit), .sda_drive(sda_drive), .sda_pin(sda_pin),
    .mode_master(mode_master), .mode_tx(mode_tx), .mode_sync(mode_sync),
    .ack_chk_en(ack_chk_en), .rd_status(rd_status), .wr_status(wr_status),
    .wr_data(wr_data), .rd_rxdata(rd_rxdata), .irq_en(irq_en),
    .status_out(status_out), .irq(irq));

  task automatic clear_ins();
    {ev_rx_xfer, ev_ack_sampled, ack_nack, ev_stop, ev_scl_rise, ev_start, ev_last_bit} = '0;
    {sda_drive, sda_pin, mode_master, mode_tx, mode_sync, ack_chk_en} = '0;
    {rd_status, wr_status, rd_rxdata} = '0;
    wr_data = '0;
    irq_en  = '0;
  endtask

  task automatic expect_st(logic [7:0] st, logic ir, string tag);
    item_t it;
    it.st = st; it.ir = ir; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic next_cycle();
    @(negedge clk);
    clear_ins();
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (status_out !== it.st || irq !== it.ir) begin
        fails++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                 it.tag, status_out, irq, it.st, it.ir);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_ins();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    next_cycle(); expect_st(8'h00, 0, "R1 reset state");

    next_cycle(); ev_rx_xfer = 1; expect_st(RDF, 0, "R2 rx set");
    next_cycle(); expect_st(RDF, 0, "R2 hold");
    next_cycle(); wr_status = 1; wr_data = 8'h00; expect_st(RDF, 0, "R3 write0 unarmed");
    next_cycle(); rd_status = 1; expect_st(RDF, 0, "R3 read arms");
    next_cycle(); wr_status = 1; wr_data = 8'hFF; expect_st(RDF, 0, "R3 write1 no effect");
    next_cycle(); wr_status = 1; wr_data = 8'h00; expect_st(RDF, 0, "R3 disarmed by write");
    next_cycle(); rd_status = 1; expect_st(RDF, 0, "R3 read arms again");
    next_cycle(); wr_status = 1; wr_data = 8'h00; expect_st(8'h00, 0, "R3 armed clear");
    next_cycle(); ev_rx_xfer = 1; expect_st(RDF, 0, "R2 rx set again");
    next_cycle(); rd_rxdata = 1; expect_st(8'h00, 0, "R2 data read clears");

    next_cycle(); mode_tx = 1; ev_ack_sampled = 1; ack_nack = 1; expect_st(8'h00, 0, "R4 check disabled");
    next_cycle(); mode_tx = 1; ev_ack_sampled = 1; ack_nack = 1; ack_chk_en = 1; expect_st(NAK, 0, "R4 nack set");
    next_cycle(); mode_tx = 1; ev_ack_sampled = 1; ack_chk_en = 1; expect_st(NAK, 0, "R4 ack keeps");
    next_cycle(); rd_status = 1; expect_st(NAK, 0, "R4 read");
    next_cycle(); wr_status = 1; expect_st(8'h00, 0, "R4 cleared");

    next_cycle(); ev_stop = 1; expect_st(STP, 0, "R5 stop after frame");
    next_cycle(); rd_status = 1; expect_st(STP, 0, "R5 read");
    next_cycle(); wr_status = 1; expect_st(8'h00, 0, "R5 cleared");
    next_cycle(); ev_stop = 1; expect_st(8'h00, 0, "R5 stop without frame");

    next_cycle(); mode_master = 1; mode_tx = 1; ev_scl_rise = 1; sda_drive = 1; expect_st(ALO, 0, "R6 mismatch");
    next_cycle(); rd_status = 1; expect_st(ALO, 0, "R6 read");
    next_cycle(); wr_status = 1; expect_st(8'h00, 0, "R6 cleared");
    next_cycle(); mode_tx = 1; ev_scl_rise = 1; sda_drive = 1; expect_st(8'h00, 0, "R6 not master");
    next_cycle(); mode_master = 1; mode_tx = 1; ev_scl_rise = 1; sda_drive = 1; sda_pin = 1; expect_st(8'h00, 0, "R6 match");
    next_cycle(); mode_master = 1; ev_start = 1; sda_drive = 1; sda_pin = 1; expect_st(ALO, 0, "R7 start while high");
    next_cycle(); rd_status = 1; expect_st(ALO, 0, "R7 read");
    next_cycle(); wr_status = 1; expect_st(8'h00, 0, "R7 cleared");
    next_cycle(); mode_master = 1; ev_start = 1; expect_st(8'h00, 0, "R7 start while low");

    next_cycle(); mode_sync = 1; ev_last_bit = 1; expect_st(8'h00, 0, "R8 no overrun");
    next_cycle(); mode_sync = 1; ev_rx_xfer = 1; expect_st(RDF, 0, "R8 fill");
    next_cycle(); mode_sync = 1; ev_last_bit = 1; expect_st(RDF | ALO, 0, "R8 overrun");

    next_cycle(); rd_status = 1; expect_st(RDF | ALO, 0, "R9 read");
    next_cycle(); wr_status = 1; ev_rx_xfer = 1; expect_st(RDF, 0, "R9 set beats write clear");
    next_cycle(); rd_rxdata = 1; ev_rx_xfer = 1; expect_st(RDF, 0, "R9 set beats data read");

    next_cycle(); irq_en = 8'h20; expect_st(RDF, 1, "R10 enabled flag");
    next_cycle(); irq_en = 8'hDF; expect_st(RDF, 0, "R10 other enables");
    next_cycle(); irq_en = 8'hFF; rd_rxdata = 1; expect_st(8'h00, 0, "R10 no flags");

    next_cycle();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule